// File: doc/BRIEF.md
# LCD Frame Polarity Timing Generator

This block produces the row-side timing for a passive-matrix LCD driver: a line clock, a one-line frame sync pulse, two auxiliary phase signals, a display-off strobe and the FR polarity signal that alternates the liquid-crystal drive. The line period comes from one of two sources. The first is an internal divider, which runs from a clock-enable that an oscillator-on command starts. The second is an external line clock taken from a pin.

Several chips can share one panel. One chip works as master and drives the timing pins. The others work as slaves, receive those pins and use the master's FR and sync in place of their own. A mode pin and a clock-select pin together decide which pins are driven. The output-enable of each pin is brought out as a separate port. FR can alternate once per frame, or once every 4×(a+1) lines when n-line inversion is programmed with value a. Changes to the frame length and to the inversion setting are held back until the next frame boundary, so that a frame is never cut short.

Top module: `lcd_fr_timing`

## Requirements
- R1: After reset the block is at line 0 with the sync output high, FR low, both phase outputs low and the internal line clock stopped (clock output low).
- R2: The sync output is high exactly while the line counter is at line 0. A frame lasts dutyData+1 lines, and the default is DUTY_DEF+1 = 8 lines.
- R3: With n-line inversion disabled, FR toggles on the line step that ends each frame.
- R4: With n-line inversion enabled at value a, FR toggles every 4×(a+1) line steps, counted from the frame boundary where the setting took effect. Frame boundaries then do not toggle FR. The toggle on the boundary where the setting is applied still follows the old mode.
- R5: A write of the frame length or of the inversion setting takes effect at the next frame boundary. The frame in progress keeps its old settings.
- R6: The internal line clock runs only when masterMode=1 and clkSel=1, and only after an oscOnCmd pulse has been seen in that state. Leaving that state stops it.
- R7: When masterMode=1 and clkSel=1, every output-enable (clOe, frOe, syncOe, f1Oe, f2Oe, dofOe) is 1.
- R8: When masterMode=1 and clkSel=0, clOe is 0 and the other five output-enables are 1.
- R9: When masterMode=0, all six output-enables are 0 for either clkSel level.
- R10: When the line clock comes from the pin (clkSel=0, or slave mode), each rising edge of clIn advances exactly one line. When the internal source is selected, clIn has no effect.
- R11: In slave mode, frActive and syncActive follow frIn and syncIn through a two-flop synchroniser. In master mode they follow the block's own FR and sync.
- R12: f1Out is 1 on odd lines. f2Out toggles at each frame boundary. dofOut follows displayOn one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1 = master, 0 = slave |
| clkSel | input | 1 | 1 = internal line clock, 0 = line clock from pin |
| oscOnCmd | input | 1 | One-cycle pulse that starts the internal line clock |
| clIn | input | 1 | Line clock received from the pin |
| frIn | input | 1 | FR received from the master |
| syncIn | input | 1 | Sync received from the master |
| displayOn | input | 1 | Display enable, copied to the display-off strobe |
| dutyWe | input | 1 | Write strobe for the frame length |
| dutyData | input | LINE_W | Frame length minus one, in lines |
| invWe | input | 1 | Write strobe for the inversion setting |
| invEn | input | 1 | 1 = n-line inversion, 0 = per-frame alternation |
| invVal | input | INV_W | Inversion value a (period 4×(a+1) lines) |
| clOut | output | 1 | Internal line clock, high for the first half of each line |
| clOe | output | 1 | Drive enable for the line-clock pin |
| frOut | output | 1 | FR polarity |
| frOe | output | 1 | Drive enable for FR |
| syncOut | output | 1 | Frame sync, high during line 0 |
| syncOe | output | 1 | Drive enable for sync |
| f1Out | output | 1 | Line-parity phase |
| f1Oe | output | 1 | Drive enable for f1 |
| f2Out | output | 1 | Frame-parity phase |
| f2Oe | output | 1 | Drive enable for f2 |
| dofOut | output | 1 | Display-off strobe (low = display off) |
| dofOe | output | 1 | Drive enable for the display-off strobe |
| frActive | output | 1 | FR used by the row driver |
| syncActive | output | 1 | Sync used by the row driver |

## Verification
A line counter that drifts shows up at the sync output within one frame (at most dutyData+1 line steps), because sync must be high on line 0 and on no other line. A wrong inversion counter or a wrong applied setting changes the line on which FR flips, so it shows within one inversion period. A wrong oscillator state or a wrong pin-direction decode shows at clOut and at the output-enables within two clocks of a mode change.

// File: rtl/lcd_fr_pkg.sv
package lcd_fr_pkg;
  typedef struct packed {
    logic lineStep;   // advance one display line this cycle
    logic slaveMode;  // use master-supplied FR/sync
  } lcdCtl_t;
endpackage

// File: rtl/lcd_fr_ctrl.sv
module lcd_fr_ctrl
  import lcd_fr_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    masterMode,
  input  logic    clkSel,
  input  logic    oscOnCmd,
  input  logic    clIn,
  output lcdCtl_t ctl,
  output logic    clOut,
  output logic    clOe,
  output logic    frOe,
  output logic    syncOe,
  output logic    f1Oe,
  output logic    f2Oe,
  output logic    dofOe
);
  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(DIV / 2);

  logic internalSrc;
  logic oscRun;
  logic [DIV_W-1:0] divCnt;
  logic [1:0] clSync;
  logic clPrev;
  logic intStep, extStep;

  assign internalSrc = masterMode & clkSel;

  // oscillator enable: set by command, dropped when the source is deselected
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             oscRun <= 1'b0;
    else if (!internalSrc) oscRun <= 1'b0;
    else if (oscOnCmd)     oscRun <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               divCnt <= '0;
    else if (!oscRun)        divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                     divCnt <= divCnt + 1'b1;
  end

  // external line clock: two-flop synchroniser plus rising-edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clSync <= '0;
      clPrev <= 1'b0;
    end else begin
      clSync <= {clSync[0], clIn};
      clPrev <= clSync[1];
    end
  end

  assign intStep = oscRun && (divCnt == DIV_LAST);
  assign extStep = clSync[1] & ~clPrev;

  always_comb begin
    ctl.lineStep  = internalSrc ? intStep : extStep;
    ctl.slaveMode = ~masterMode;
  end

  assign clOut  = oscRun && (divCnt < DIV_HALF);

  // pin direction table
  assign clOe   = internalSrc;
  assign frOe   = masterMode;
  assign syncOe = masterMode;
  assign f1Oe   = masterMode;
  assign f2Oe   = masterMode;
  assign dofOe  = masterMode;
endmodule

// File: rtl/lcd_fr_dpath.sv
module lcd_fr_dpath
  import lcd_fr_pkg::*;
#(
  parameter int LINE_W   = 8,
  parameter int INV_W    = 4,
  parameter int DUTY_DEF = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  lcdCtl_t           ctl,
  input  logic              dutyWe,
  input  logic [LINE_W-1:0] dutyData,
  input  logic              invWe,
  input  logic              invEn,
  input  logic [INV_W-1:0]  invVal,
  input  logic              displayOn,
  input  logic              frIn,
  input  logic              syncIn,
  output logic              frOut,
  output logic              syncOut,
  output logic              f1Out,
  output logic              f2Out,
  output logic              dofOut,
  output logic              frActive,
  output logic              syncActive
);
  localparam int NL_W = INV_W + 2;

  logic [LINE_W-1:0] lineCnt, dutyCur, dutyPend;
  logic              dutyPendV;
  logic              invCurEn, invPendEn, invPendV;
  logic [INV_W-1:0]  invCurVal, invPendVal;
  logic [NL_W-1:0]   nlCnt;
  logic              fr, f2, dof;
  logic [1:0]        frSync, syncSyncR;
  logic              frameEnd, nlLast;

  assign frameEnd = ctl.lineStep && (lineCnt == dutyCur);
  assign nlLast   = (nlCnt == {invCurVal, 2'b11});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt <= '0;
      dutyCur <= LINE_W'(DUTY_DEF);
      dutyPend <= '0;
      dutyPendV <= 1'b0;
      invCurEn <= 1'b0;
      invCurVal <= '0;
      invPendEn <= 1'b0;
      invPendVal <= '0;
      invPendV <= 1'b0;
      nlCnt <= '0;
      fr <= 1'b0;
      f2 <= 1'b0;
    end else begin
      if (ctl.lineStep) begin
        lineCnt <= frameEnd ? '0 : lineCnt + 1'b1;
        if (invCurEn) begin
          nlCnt <= nlLast ? '0 : nlCnt + 1'b1;
          if (nlLast) fr <= ~fr;
        end else if (frameEnd) begin
          fr <= ~fr;
        end
      end
      if (frameEnd) begin
        f2 <= ~f2;
        if (dutyPendV) begin
          dutyCur   <= dutyPend;
          dutyPendV <= 1'b0;
        end
        if (invPendV) begin
          invCurEn  <= invPendEn;
          invCurVal <= invPendVal;
          invPendV  <= 1'b0;
          nlCnt     <= '0;
        end
      end
      // a write in the same cycle as a boundary stays pending
      if (dutyWe) begin
        dutyPend  <= dutyData;
        dutyPendV <= 1'b1;
      end
      if (invWe) begin
        invPendEn  <= invEn;
        invPendVal <= invVal;
        invPendV   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dof       <= 1'b0;
      frSync    <= '0;
      syncSyncR <= '0;
    end else begin
      dof       <= displayOn;
      frSync    <= {frSync[0], frIn};
      syncSyncR <= {syncSyncR[0], syncIn};
    end
  end

  assign frOut      = fr;
  assign syncOut    = (lineCnt == '0);
  assign f1Out      = lineCnt[0];
  assign f2Out      = f2;
  assign dofOut     = dof;
  assign frActive   = ctl.slaveMode ? frSync[1] : fr;
  assign syncActive = ctl.slaveMode ? syncSyncR[1] : syncOut;
endmodule

// File: rtl/lcd_fr_timing.sv
module lcd_fr_timing
  import lcd_fr_pkg::*;
#(
  parameter int DIV      = 4,
  parameter int LINE_W   = 8,
  parameter int INV_W    = 4,
  parameter int DUTY_DEF = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterMode,
  input  logic              clkSel,
  input  logic              oscOnCmd,
  input  logic              clIn,
  input  logic              frIn,
  input  logic              syncIn,
  input  logic              displayOn,
  input  logic              dutyWe,
  input  logic [LINE_W-1:0] dutyData,
  input  logic              invWe,
  input  logic              invEn,
  input  logic [INV_W-1:0]  invVal,
  output logic              clOut,
  output logic              clOe,
  output logic              frOut,
  output logic              frOe,
  output logic              syncOut,
  output logic              syncOe,
  output logic              f1Out,
  output logic              f1Oe,
  output logic              f2Out,
  output logic              f2Oe,
  output logic              dofOut,
  output logic              dofOe,
  output logic              frActive,
  output logic              syncActive
);
  lcdCtl_t ctlS;

  lcd_fr_ctrl #(.DIV(DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .clkSel(clkSel),
    .oscOnCmd(oscOnCmd), .clIn(clIn), .ctl(ctlS), .clOut(clOut),
    .clOe(clOe), .frOe(frOe), .syncOe(syncOe), .f1Oe(f1Oe),
    .f2Oe(f2Oe), .dofOe(dofOe)
  );

  lcd_fr_dpath #(.LINE_W(LINE_W), .INV_W(INV_W), .DUTY_DEF(DUTY_DEF)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctlS), .dutyWe(dutyWe), .dutyData(dutyData),
    .invWe(invWe), .invEn(invEn), .invVal(invVal), .displayOn(displayOn),
    .frIn(frIn), .syncIn(syncIn), .frOut(frOut), .syncOut(syncOut),
    .f1Out(f1Out), .f2Out(f2Out), .dofOut(dofOut), .frActive(frActive),
    .syncActive(syncActive)
  );
endmodule

// File: rtl/lcd_fr_timing_chk.sv
module lcd_fr_timing_chk (
  input logic clk,
  input logic rstN,
  input logic masterMode,
  input logic clkSel,
  input logic lineStep,
  input logic displayOn,
  input logic clOut,
  input logic clOe,
  input logic frOe,
  input logic syncOe,
  input logic f1Oe,
  input logic f2Oe,
  input logic dofOe,
  input logic frOut,
  input logic syncOut,
  input logic dofOut
);
  // R9
  slave_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> !(clOe | frOe | syncOe | f1Oe | f2Oe | dofOe));
  // R7
  master_int_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && clkSel) |-> (clOe && frOe && syncOe && f1Oe && f2Oe && dofOe));
  // R8
  master_ext_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !clkSel) |-> (!clOe && frOe && syncOe && f1Oe && f2Oe && dofOe));
  // R6
  osc_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(masterMode && clkSel) |=> !clOut);
  // R3
  fr_on_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineStep |=> frOut == $past(frOut));
  // R2
  sync_on_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineStep |=> syncOut == $past(syncOut));
  // R12
  dof_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> dofOut == $past(displayOn));
endmodule

bind lcd_fr_timing lcd_fr_timing_chk u_chk (
  .clk(clk), .rstN(rstN), .masterMode(masterMode), .clkSel(clkSel),
  .lineStep(ctlS.lineStep), .displayOn(displayOn), .clOut(clOut),
  .clOe(clOe), .frOe(frOe), .syncOe(syncOe), .f1Oe(f1Oe), .f2Oe(f2Oe),
  .dofOe(dofOe), .frOut(frOut), .syncOut(syncOut), .dofOut(dofOut)
);

// File: tb/lcd_fr_timing_tb.sv
`timescale 1ns/1ps
module lcd_fr_timing_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1, clkSel = 1'b0, oscOnCmd = 1'b0, clIn = 1'b0;
  logic frIn = 1'b0, syncIn = 1'b0, displayOn = 1'b0;
  logic dutyWe = 1'b0, invWe = 1'b0, invEn = 1'b0;
  logic [7:0] dutyData = '0;
  logic [3:0] invVal = '0;
  logic clOut, clOe, frOut, frOe, syncOut, syncOe, f1Out, f1Oe, f2Out, f2Oe;
  logic dofOut, dofOe, frActive, syncActive;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  lcd_fr_timing u_dut (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .clkSel(clkSel),
    .oscOnCmd(oscOnCmd), .clIn(clIn), .frIn(frIn), .syncIn(syncIn),
    .displayOn(displayOn), .dutyWe(dutyWe), .dutyData(dutyData),
    .invWe(invWe), .invEn(invEn), .invVal(invVal), .clOut(clOut),
    .clOe(clOe), .frOut(frOut), .frOe(frOe), .syncOut(syncOut),
    .syncOe(syncOe), .f1Out(f1Out), .f1Oe(f1Oe), .f2Out(f2Out),
    .f2Oe(f2Oe), .dofOut(dofOut), .dofOe(dofOe), .frActive(frActive),
    .syncActive(syncActive)
  );

  // pulses, sync, fr, f1, f2 -- master, pin clock, 8-line frames (R2 R3 R10 R12)
  localparam int NVEC = 6;
  localparam int VEC [NVEC][5] = '{
    '{1, 0, 0, 1, 0},
    '{6, 0, 0, 1, 0},
    '{1, 1, 1, 0, 1},
    '{2, 0, 1, 0, 1},
    '{6, 1, 0, 0, 0},
    '{3, 0, 0, 1, 0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic m, input logic cs);
    masterMode = m; clkSel = cs; clIn = 1'b0; oscOnCmd = 1'b0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseCl(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) clIn = 1'b1;
      repeat (4) @(negedge clk);
      clIn = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic writeInv(input logic en, input logic [3:0] v);
    @(negedge clk) begin invWe = 1'b1; invEn = en; invVal = v; end
    @(negedge clk) invWe = 1'b0;
  endtask

  task automatic checkOe(input string tag, input int exp);
    @(negedge clk);
    chk(tag, {clOe, frOe, syncOe, f1Oe, f2Oe, dofOe}, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seen;
    doReset(1'b1, 1'b0);
    // R1 reset state
    chk("R1 sync", syncOut, 1);
    chk("R1 fr", frOut, 0);
    chk("R1 f1f2", {f1Out, f2Out}, 0);
    chk("R1 cl", clOut, 0);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      pulseCl(VEC[v][0]);
      chk("R2 sync", syncOut, VEC[v][1]);
      chk("R3 fr", frOut, VEC[v][2]);
      chk("R12 f1", f1Out, VEC[v][3]);
      chk("R12 f2", f2Out, VEC[v][4]);
    end

    // R4 n-line inversion a=0: period 4 lines after applying boundary
    doReset(1'b1, 1'b0);
    writeInv(1'b1, 4'd0);
    pulseCl(8);
    chk("R4 apply boundary fr", frOut, 1);
    pulseCl(3);
    chk("R4 a0 before toggle", frOut, 1);
    pulseCl(1);
    chk("R4 a0 toggle", frOut, 0);
    pulseCl(4);
    chk("R4 a0 second toggle", frOut, 1);
    chk("R4 sync at frame edge", syncOut, 1);

    // R4 a=1: period 8 lines
    doReset(1'b1, 1'b0);
    writeInv(1'b1, 4'd1);
    pulseCl(8);
    pulseCl(7);
    chk("R4 a1 hold", frOut, 1);
    pulseCl(1);
    chk("R4 a1 toggle", frOut, 0);

    // R5 duty write deferred to next boundary
    doReset(1'b1, 1'b0);
    @(negedge clk) begin dutyWe = 1'b1; dutyData = 8'd3; end
    @(negedge clk) dutyWe = 1'b0;
    pulseCl(7);
    chk("R5 old frame kept", syncOut, 0);
    pulseCl(1);
    chk("R5 boundary", syncOut, 1);
    pulseCl(4);
    chk("R5 new 4-line frame", syncOut, 1);
    pulseCl(2);
    chk("R5 mid frame", syncOut, 0);

    // R7 R8 R9 direction table
    masterMode = 1'b1; clkSel = 1'b1; checkOe("R7 oe", 6'b111111);
    masterMode = 1'b1; clkSel = 1'b0; checkOe("R8 oe", 6'b011111);
    masterMode = 1'b0; clkSel = 1'b1; checkOe("R9 oe cs1", 0);
    masterMode = 1'b0; clkSel = 1'b0; checkOe("R9 oe cs0", 0);

    // R6 R10 internal source
    doReset(1'b1, 1'b1);
    seen = 0;
    pulseCl(2);
    chk("R10 pin ignored", syncOut, 1);
    repeat (40) @(negedge clk) if (clOut) seen++;
    chk("R6 no osc before cmd", seen, 0);
    @(negedge clk) oscOnCmd = 1'b1;
    @(negedge clk) oscOnCmd = 1'b0;
    seen = 0;
    repeat (40) @(negedge clk) if (clOut) seen++;
    chk("R6 osc running", seen > 0, 1);
    @(negedge clk) clkSel = 1'b0;
    repeat (2) @(negedge clk);
    seen = 0;
    repeat (20) @(negedge clk) if (clOut) seen++;
    chk("R6 osc stopped", seen, 0);

    // R6 slave ignores oscillator command
    doReset(1'b0, 1'b1);
    @(negedge clk) oscOnCmd = 1'b1;
    @(negedge clk) oscOnCmd = 1'b0;
    seen = 0;
    repeat (20) @(negedge clk) if (clOut) seen++;
    chk("R6 slave no osc", seen, 0);

    // R11 slave follows master inputs
    @(negedge clk) begin frIn = 1'b1; syncIn = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R11 slave fr", frActive, 1);
    chk("R11 slave sync", syncActive, 0);
    @(negedge clk) begin frIn = 1'b0; syncIn = 1'b1; end
    repeat (3) @(negedge clk);
    chk("R11 slave fr low", frActive, 0);
    chk("R11 slave sync high", syncActive, 1);
    doReset(1'b1, 1'b0);
    @(negedge clk) begin frIn = 1'b1; syncIn = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R11 master own fr", frActive, 0);
    chk("R11 master own sync", syncActive, 1);

    // R12 display-off strobe
    @(negedge clk) displayOn = 1'b1;
    @(negedge clk);
    chk("R12 dof on", dofOut, 1);
    displayOn = 1'b0;
    @(negedge clk);
    chk("R12 dof off", dofOut, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule